// File: doc/BRIEF.md
# Addressed Serial Output Control Register

This block is a three-wire serial slave with an active-low select, a serial clock, a data input and a data output. The host sends 16-bit frames made of an 8-bit address followed by an 8-bit data byte. When the select line is released, the block applies the data byte to one of two internal registers, chosen by the address. Address 00h writes the eight output-enable levels. Address 01h writes the power-save configuration byte. A frame with any other address is dropped, and its bits stay only in the shift register.

The three serial lines are brought into the system clock domain through synchronizer chains. Their edges are then detected from the synchronized levels. Serial data is captured on rising serial-clock edges. The data output moves on falling edges, so several devices can be chained with one device's output feeding the next one's input. The interface is a plain serial port with no valid/ready handshake, and the block applies no back-pressure: every frame that is released is either committed or dropped at once.

Top module: `addr_out_ctl`

## Requirements
- R1: A frame is shifted in most significant bit first. Its first 8 bits form the address and its last 8 bits form the data byte.
- R2: While the select input is low, the output-enable and power-save outputs keep their previous values. They change only after the select input rises.
- R3: If more or fewer than 16 serial clocks arrive during one select-low period, the commit uses the 16 most recently received bits. With fewer than 16 clocks, the older bits come from the shift register's earlier contents.
- R4: When the committed address is neither 00h nor 01h, neither the output-enable nor the power-save output changes.
- R5: While the select input is high, activity on the serial clock and data inputs has no effect on the shift register, and the data output shows the shift register's most significant bit.
- R6: Data bit N drives `out_en[N]`, which is output N+1. A 1 turns the output on and a 0 turns it off. For example, data 04h turns on only the third output.
- R7: Address 00h loads the data byte into `out_en`. Address 01h loads it into `psave_cfg`. A single commit never writes both.
- R8: While the select input is low, the data output changes only after a falling serial-clock edge. It presents the bit that left the shift register, so a full frame shifts out the previous 16-bit contents MSB first.
- R9: An active-low reset clears the shift register, `out_en`, `psave_cfg` and the data output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial select, active low; a rising edge commits the frame |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_data_in | input | 1 | Serial data in, captured on rising `ser_clk` |
| ser_data_out | output | 1 | Serial data out for chaining, updated on falling `ser_clk` |
| out_en | output | 8 | Output-enable levels; bit N drives output N+1 |
| psave_cfg | output | 8 | Power-save configuration byte |

## Verification
A corrupt shift register shows up at `ser_data_out`. The next frame shifts the held bits out and compares them one serial clock at a time, so a fault is seen within 16 serial clocks. The same corruption also changes the committed byte, and this is visible a few system cycles after the select line rises. A wrong address decode, or an update that leaks during select-low, is visible at `out_en` or `psave_cfg` on the first commit or mid-frame sample after the fault.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_OUTS  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PSAVE = 8'h01;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/aoc_line_sync.sv
module aoc_line_sync #(
  parameter int          LINES   = 3,
  parameter int          STAGES  = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] stg [STAGES];
  logic [LINES-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= raw;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign level = stg[STAGES-1];

  for (genvar g = 0; g < LINES; g++) begin : g_edge
    assign rise[g] = level[g] & ~prev[g];
    assign fall[g] = ~level[g] & prev[g];
  end
endmodule

// File: rtl/aoc_shifter.sv
module aoc_shifter
  import aoc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_act,
  input  logic   sck_rise,
  input  logic   sck_fall,
  input  logic   din,
  output frame_t frame,
  output logic   dout
);
  logic [FRAME_W-1:0] sh_q;
  logic               dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      if (sel_act && sck_rise) sh_q <= {sh_q[FRAME_W-2:0], din};
      if (!sel_act || sck_fall) dout_q <= sh_q[FRAME_W-1];
    end
  end

  assign frame = frame_t'(sh_q);
  assign dout  = dout_q;

  p_idle_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> $stable(sh_q));
  p_dout_rise_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act && !sck_fall) |=> $stable(dout_q));
endmodule

// File: rtl/aoc_commit.sv
module aoc_commit
  import aoc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  frame_t            frame,
  output logic [DATA_W-1:0] out_en,
  output logic [DATA_W-1:0] psave_cfg
);
  logic wr_outs, wr_psave, addr_bad;

  assign wr_outs  = commit && (frame.addr == ADDR_OUTS);
  assign wr_psave = commit && (frame.addr == ADDR_PSAVE);
  assign addr_bad = (frame.addr != ADDR_OUTS) && (frame.addr != ADDR_PSAVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en    <= '0;
      psave_cfg <= '0;
    end else begin
      if (wr_outs)  out_en    <= frame.data;
      if (wr_psave) psave_cfg <= frame.data;
    end
  end

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_outs, wr_psave}));
  p_outs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_outs |=> (out_en == $past(frame.data)) && $stable(psave_cfg));
  p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr_bad) |=> $stable(out_en) && $stable(psave_cfg));
endmodule

// File: rtl/addr_out_ctl.sv
module addr_out_ctl
  import aoc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_data_in,
  output logic              ser_data_out,
  output logic [DATA_W-1:0] out_en,
  output logic [DATA_W-1:0] psave_cfg
);
  localparam int IDX_SEL = 2;
  localparam int IDX_CLK = 1;
  localparam int IDX_DIN = 0;

  logic [2:0] lvl, rse, fll;
  frame_t     frame;
  logic       sel_act;

  aoc_line_sync #(.LINES(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({ser_sel_n, ser_clk, ser_data_in}),
    .level (lvl),
    .rise  (rse),
    .fall  (fll)
  );

  assign sel_act = ~lvl[IDX_SEL];

  aoc_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_act  (sel_act),
    .sck_rise (rse[IDX_CLK]),
    .sck_fall (fll[IDX_CLK]),
    .din      (lvl[IDX_DIN]),
    .frame    (frame),
    .dout     (ser_data_out)
  );

  aoc_commit u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (rse[IDX_SEL]),
    .frame     (frame),
    .out_en    (out_en),
    .psave_cfg (psave_cfg)
  );

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act |=> $stable(out_en) && $stable(psave_cfg));
endmodule

// File: tb/addr_out_ctl_tb_top.sv
module addr_out_ctl_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, din = 1'b0;
  logic dout;
  logic [7:0] out_en, psave_cfg;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [15:0] m_sh = '0;
  logic [7:0]  m_out = '0, m_ps = '0;
  logic [15:0] exp_q[$];
  logic        mon_go = 1'b0;
  logic        mon_ack = 1'b0;

  always #2.5ns clk = ~clk;

  addr_out_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sck),
    .ser_data_in(din), .ser_data_out(dout), .out_en(out_en), .psave_cfg(psave_cfg)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: shifts n bits of val MSB first, releases select, pushes expectation.
  task automatic send(input logic [31:0] val, input int n);
    sel_n = 1'b0;
    wait_cyc(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      din = val[i];
      wait_cyc(HALF);
      check(dout === m_sh[15], "R8 dout before rise", {15'd0, dout}, {15'd0, m_sh[15]});
      sck = 1'b1;
      wait_cyc(HALF);
      check(dout === m_sh[15], "R8 dout held after rise", {15'd0, dout}, {15'd0, m_sh[15]});
      m_sh = {m_sh[14:0], val[i]};
      if (i == n / 2)
        check({out_en, psave_cfg} === {m_out, m_ps}, "R2 hold while selected",
              {out_en, psave_cfg}, {m_out, m_ps});
      sck = 1'b0;
      wait_cyc(HALF);
    end
    sel_n = 1'b1;
    if (m_sh[15:8] == 8'h00) m_out = m_sh[7:0];
    else if (m_sh[15:8] == 8'h01) m_ps = m_sh[7:0];
    exp_q.push_back({m_out, m_ps});
    wait_cyc(10);
    mon_go = 1'b1;
    wait (mon_ack);
    mon_go = 1'b0;
    wait (!mon_ack);
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      wait (mon_go);
      if (exp_q.size() == 0) check(1'b0, "R7 scoreboard empty", 16'h0, 16'h1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({out_en, psave_cfg} === e, "R1/R4/R6/R7 committed outputs", {out_en, psave_cfg}, e);
      end
      mon_ack = 1'b1;
      wait (!mon_go);
      mon_ack = 1'b0;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #500us;
    check(1'b0, "watchdog expired", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    wait_cyc(5);
    // R9: reset state
    check(out_en === 8'h00, "R9 out_en reset", {8'h0, out_en}, 16'h0);
    check(psave_cfg === 8'h00, "R9 psave reset", {8'h0, psave_cfg}, 16'h0);
    check(dout === 1'b0, "R9 dout reset", {15'd0, dout}, 16'h0);
    rst_n = 1'b1;
    wait_cyc(5);

    send(32'h00A5, 16);                        // R1 R7: outputs
    send(32'h013C, 16);                        // R7: power-save
    send(32'h0204, 16);                        // R4: dropped
    check(out_en === 8'hA5 && psave_cfg === 8'h3C, "R4 bad address unchanged",
          {out_en, psave_cfg}, 16'hA53C);
    send(32'h0004, 16);                        // R6: third output only
    check(out_en[2] === 1'b1 && $countones(out_en) == 1, "R6 bit2 to third output",
          {8'h0, out_en}, 16'h0004);
    send(32'h50055, 20);                       // R3: long frame, last 16 used
    check(out_en === 8'h55, "R3 long frame", {8'h0, out_en}, 16'h0055);
    send(32'h7001, 16);                        // R4: dropped, primes shift reg
    send(32'h99, 8);                           // R3: short frame -> 0199
    check(psave_cfg === 8'h99, "R3 short frame", {8'h0, psave_cfg}, 16'h0099);

    // R5: activity while deselected is ignored
    din = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sck = 1'b1; wait_cyc(HALF);
      sck = 1'b0; wait_cyc(HALF);
    end
    check(dout === m_sh[15], "R5 dout idle shows MSB", {15'd0, dout}, {15'd0, m_sh[15]});
    check({out_en, psave_cfg} === {m_out, m_ps}, "R5 outputs unaffected while idle",
          {out_en, psave_cfg}, {m_out, m_ps});
    send(32'h0, 0);                            // R5: commit without clocks reuses 0199
    check(psave_cfg === 8'h99 && out_en === 8'h55, "R5 shift reg intact",
          {out_en, psave_cfg}, 16'h5599);
    send(32'h80FF, 16);                        // R8: shifts 0199 out, R4 drop
    send(32'h00FF, 16);                        // R6: all outputs on
    finish_run();
  end
endmodule